// File: doc/BRIEF.md
# Rotating Slot Arbiter with Opt-In Slot Sharing

This block decides, once per clock, which of several cores may use a shared memory port. A slot pointer steps through the cores in turn, one position per cycle. By default only the core the pointer names can be served in that cycle. This makes each core's access timing fixed and independent of what the other cores are doing.

Two options per core loosen that schedule, and both are off after reset. With the sharing option, a core lets others use its slot. A policy bit chooses how: either only in cycles where the core itself is not asking, or always, with its own request served only when nobody else wants the slot. With the scavenging option, a core may take a slot that its owner has made available. Scavenging never takes a slot by force. A requesting owner that has not chosen the "others first" policy always keeps its slot.

Option inputs are sampled into registers, so a change applies from the next cycle. Requests act in the same cycle. The outputs are a one-hot grant and the index of the current slot owner.

Top module: `slot_arb`

## Requirements
- R1: While reset is held, slotOwner is 0 and no grant is asserted when no core requests. After reset, sharing and scavenging are off for every core until an option input has been sampled by a clock edge.
- R2: slotOwner advances by one on every clock edge, wrapping from NCORE-1 to 0.
- R3: At most one grant bit is high in any cycle, and a grant only goes to a core whose reqIn bit is high.
- R4: With every option off, grant equals the one-hot of slotOwner when the owner requests, and is zero otherwise.
- R5: An owner whose sharing option is on with donatePrio = 0 (idle-only policy) keeps its slot whenever it requests.
- R6: When the owner has sharing on with donatePrio = 0 and is not requesting, the slot goes to a requesting core whose claimEn is on. If there is no such core, no grant is issued.
- R7: When the owner has sharing on with donatePrio = 1 (others-first policy), a requesting scavenger wins over the requesting owner. The owner is granted only when no scavenger requests.
- R8: A core with claimEn off is never granted a slot other than its own.
- R9: Among several eligible scavengers, the winner is the first requester met scanning upward from slotOwner+1, wrapping past NCORE-1 to 0.
- R10: An option change presented in a cycle leaves that cycle's grant unchanged and takes effect from the following cycle.
- R11: donatePrio has no effect while the owner's sharing option (donateEn) is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqIn | input | NCORE | Per-core access request, acts this cycle |
| donateEn | input | NCORE | Per-core sharing option, sampled at the clock edge |
| donatePrio | input | NCORE | Sharing policy: 0 idle-only, 1 others-first |
| claimEn | input | NCORE | Per-core scavenging option, sampled at the clock edge |
| grant | output | NCORE | One-hot access grant for this cycle |
| slotOwner | output | $clog2(NCORE) | Index of the core that owns the current slot |

## Verification
Two things can land in the same cycle. One is the owner's own request and a scavenger's bid for a slot shared under the others-first policy. The other is an option write together with the grant decision it must not yet affect. Directed cycles set up both collisions with requests placed relative to the owner for that cycle. Long random runs toggle options while requests are live, so writes routinely coincide with contested slots. Each cycle's grant is compared with a bench model that applies option values one cycle late and resolves contention by the upward scan.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  // Strobes from the slot controller to the grant datapath.
  typedef struct packed {
    logic slotOpen;   // owner lets scavengers use this slot
    logic ownerReq;   // owner is asking for its slot
  } slotCtl_t;
endpackage

// File: rtl/slot_arb_ctrl.sv
module slot_arb_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int IDXW  = $clog2(NCORE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] reqIn,
  input  logic [NCORE-1:0] donateEn,
  input  logic [NCORE-1:0] donatePrio,
  input  logic [NCORE-1:0] claimEn,
  output logic [IDXW-1:0]  ownerIdx,
  output logic [NCORE-1:0] ownerHot,
  output logic [NCORE-1:0] claimMask,
  output slotCtl_t         ctl
);
  logic [NCORE-1:0] donQ, prioQ, clmQ;

  // Slot pointer plus option registers; options apply one cycle after sampling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ownerIdx <= '0;
      donQ     <= '0;
      prioQ    <= '0;
      clmQ     <= '0;
    end else begin
      ownerIdx <= (ownerIdx == IDXW'(NCORE - 1)) ? '0 : ownerIdx + 1'b1;
      donQ     <= donateEn;
      prioQ    <= donatePrio;
      clmQ     <= claimEn;
    end
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_hot
    assign ownerHot[g] = (ownerIdx == IDXW'(g));
  end

  logic ownReq, ownDon, ownPrio;
  always_comb begin
    ownReq  = |(reqIn & ownerHot);
    ownDon  = |(donQ & ownerHot);
    ownPrio = |(prioQ & ownerHot);
    ctl.ownerReq = ownReq;
    ctl.slotOpen = ownDon && (ownPrio || !ownReq);
  end

  assign claimMask = clmQ;
endmodule

// File: rtl/slot_arb_path.sv
module slot_arb_path
  import slot_arb_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int IDXW  = $clog2(NCORE)
) (
  input  logic [NCORE-1:0] reqIn,
  input  logic [IDXW-1:0]  ownerIdx,
  input  logic [NCORE-1:0] ownerHot,
  input  logic [NCORE-1:0] claimMask,
  input  slotCtl_t         ctl,
  output logic [NCORE-1:0] grant
);
  logic [NCORE-1:0] cand, winHot;
  logic             found;

  // Rotating scan: first scavenger after the owner, wrapping.
  always_comb begin
    cand   = reqIn & claimMask & ~ownerHot;
    winHot = '0;
    found  = 1'b0;
    for (int k = 1; k < NCORE; k++) begin
      int pos;
      pos = (int'(ownerIdx) + k) % NCORE;
      if (!found && cand[pos]) begin
        winHot[pos] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    if (ctl.slotOpen && found) grant = winHot;
    else if (ctl.ownerReq)     grant = ownerHot;
    else                       grant = '0;
  end
endmodule

// File: rtl/slot_arb.sv
module slot_arb
  import slot_arb_pkg::*;
#(
  parameter int NCORE = 8,
  localparam int IDXW = $clog2(NCORE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] reqIn,
  input  logic [NCORE-1:0] donateEn,
  input  logic [NCORE-1:0] donatePrio,
  input  logic [NCORE-1:0] claimEn,
  output logic [NCORE-1:0] grant,
  output logic [IDXW-1:0]  slotOwner
);
  logic [NCORE-1:0] ownerHot, claimMask;
  slotCtl_t         ctl;

  slot_arb_ctrl #(.NCORE(NCORE), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .donateEn(donateEn),
    .donatePrio(donatePrio), .claimEn(claimEn), .ownerIdx(slotOwner),
    .ownerHot(ownerHot), .claimMask(claimMask), .ctl(ctl)
  );

  slot_arb_path #(.NCORE(NCORE), .IDXW(IDXW)) u_path (
    .reqIn(reqIn), .ownerIdx(slotOwner), .ownerHot(ownerHot),
    .claimMask(claimMask), .ctl(ctl), .grant(grant)
  );
endmodule

// File: rtl/slot_arb_checker.sv
module slot_arb_checker #(
  parameter int NCORE = 8,
  parameter int IDXW  = $clog2(NCORE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] reqIn,
  input logic [NCORE-1:0] donateEn,
  input logic [NCORE-1:0] donatePrio,
  input logic [NCORE-1:0] claimEn,
  input logic [NCORE-1:0] grant,
  input logic [IDXW-1:0]  slotOwner
);
  logic [NCORE-1:0] donPrev, prioPrev, clmPrev, ownHot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      donPrev  <= '0;
      prioPrev <= '0;
      clmPrev  <= '0;
    end else begin
      donPrev  <= donateEn;
      prioPrev <= donatePrio;
      clmPrev  <= claimEn;
    end
  end

  assign ownHot = {{(NCORE-1){1'b0}}, 1'b1} << slotOwner;

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~reqIn) == '0);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(slotOwner) == IDXW'(NCORE - 1)) ?
      (slotOwner == '0) : (slotOwner == $past(slotOwner) + 1'b1)));

  p_owner_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reqIn & ownHot) != '0 && (donPrev & prioPrev & ownHot) == '0)
      |-> (grant == ownHot));

  p_no_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~ownHot) != '0) |->
      (((grant & clmPrev) != '0) && ((donPrev & ownHot) != '0) &&
       (((prioPrev & ownHot) != '0) || ((reqIn & ownHot) == '0))));

  p_idle_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((donPrev & ownHot) == '0) |-> ((grant & ~ownHot) == '0));
endmodule

bind slot_arb slot_arb_checker #(.NCORE(NCORE), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .donateEn(donateEn),
  .donatePrio(donatePrio), .claimEn(claimEn), .grant(grant),
  .slotOwner(slotOwner)
);

// File: tb/slot_arb_bench.sv
module slot_arb_bench;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] reqIn = '0, donateEn = '0, donatePrio = '0, claimEn = '0;
  logic [N-1:0] grant;
  logic [IW-1:0] slotOwner;

  int nChecks = 0;
  int nFail = 0;
  int mOwner = 0;
  logic [N-1:0] mDon = '0, mPrio = '0, mClm = '0;

  always #4 clk = ~clk;

  slot_arb u_slot_arb (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .donateEn(donateEn),
    .donatePrio(donatePrio), .claimEn(claimEn), .grant(grant),
    .slotOwner(slotOwner)
  );

  function automatic logic [N-1:0] bitAt(int pos);
    return N'(1) << (((pos % N) + N) % N);
  endfunction

  function automatic logic [N-1:0] expGrant(logic [N-1:0] r);
    logic open;
    logic [N-1:0] cand;
    open = mDon[mOwner] && (mPrio[mOwner] || !r[mOwner]);
    cand = r & mClm & ~bitAt(mOwner);
    if (open && cand != '0)
      for (int k = 1; k < N; k++)
        if (cand[(mOwner + k) % N]) return bitAt(mOwner + k);
    if (r[mOwner]) return bitAt(mOwner);
    return '0;
  endfunction

  function automatic string tagFor(logic [N-1:0] r);
    logic open;
    open = mDon[mOwner] && (mPrio[mOwner] || !r[mOwner]);
    if (mDon == '0 && mClm == '0) return "R4";
    if (open && $countones(r & mClm & ~bitAt(mOwner)) > 1) return "R9";
    if (open && mPrio[mOwner]) return "R7";
    if (open) return "R6";
    if (mDon[mOwner]) return "R5";
    if (mPrio[mOwner]) return "R11";
    return "R8";
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b (owner %0d)", tag, got, exp, mOwner);
    end
  endtask

  // Called just after a falling edge; ends just after the next falling edge.
  task automatic step(logic [N-1:0] r, logic [N-1:0] d, logic [N-1:0] p,
                      logic [N-1:0] c, string tag);
    reqIn = r; donateEn = d; donatePrio = p; claimEn = c;
    #2;
    check(tag, grant, expGrant(r));
    check("R2", N'(slotOwner), N'(mOwner));
    @(posedge clk);
    mOwner = (mOwner + 1) % N;
    mDon = d; mPrio = p; mClm = c;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [N-1:0] d, p, c;
    void'($urandom(32'h5EED_0A11));
    repeat (3) @(negedge clk);
    #2;
    check("R1", N'(slotOwner), '0);
    check("R1", grant, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: options presented at release are not yet active.
    step('1, '1, '1, '1, "R1");
    // R4: all options off, assorted request patterns.
    step('0, '0, '0, '0, "R4");
    step('1, '0, '0, '0, "R4");
    step(~bitAt(mOwner), '0, '0, '0, "R4");
    // R10: option write this cycle must not change this cycle's grant.
    step(bitAt(mOwner) | bitAt(mOwner + 2), '1, '1, '1, "R10");
    // R7: others-first now active; scavenger beats requesting owner.
    step(bitAt(mOwner) | bitAt(mOwner + 2), '1, '1, '1, "R7");
    // R7: owner served when no scavenger requests.
    step(bitAt(mOwner), '1, '1, '1, "R7");
    // R8: requester without scavenging option gets nothing extra.
    step(bitAt(mOwner + 3), '1, '1, '0, "R10");
    step(bitAt(mOwner + 3), '1, '1, '0, "R8");
    // R11: policy bit without sharing option.
    step(bitAt(mOwner) | bitAt(mOwner + 1), '0, '1, '1, "R10");
    step(bitAt(mOwner) | bitAt(mOwner + 1), '0, '1, '1, "R11");
    // R5 / R6: idle-only policy.
    step(bitAt(mOwner) | bitAt(mOwner + 1), '1, '0, '1, "R10");
    step(bitAt(mOwner) | bitAt(mOwner + 1), '1, '0, '1, "R5");
    step(bitAt(mOwner + 1), '1, '0, '1, "R6");
    step('0, '1, '0, '1, "R6");
    // R9: several scavengers, nearest above owner wins, also across wrap.
    step(bitAt(mOwner + 5) | bitAt(mOwner + 3) | bitAt(mOwner - 1), '1, '0, '1, "R9");
    while (mOwner != 6) step('0, '1, '0, '1, "R6");
    step(bitAt(1) | bitAt(5), '1, '0, '1, "R9");
    // Random phase with options changing while requests are live.
    d = '0; p = '0; c = '0;
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      if ($urandom_range(7) == 0) begin
        d = N'($urandom); p = N'($urandom); c = N'($urandom);
      end
      r = N'($urandom);
      step(r, d, p, c, tagFor(r));
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule